// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block gathers a set of level-sensitive interrupt lines from on-chip peripherals and presents one interrupt request to each CPU in the system. Every CPU owns a private register bank. It holds one mask (enable) word and one pending (status) word for each group of 32 sources. A source reaches a CPU only when that CPU's bank enables it, so software decides where a source goes by choosing which banks enable it. A source may go to one CPU, to several, or to none.

The block applies no priority, no vectoring, no queuing and no edge capture. A status bit is the live input level masked by the bank's enable bit, so it clears as soon as the source drops its line. An interrupt handler reads every status word of its bank to find the active sources. Enable words can only be written as whole words, so changing one bit takes a read-modify-write in software.

Top module: `irq_fanout_ctrl`

## Requirements
- R1: Bank c starts at word address c*8, where the bank index is bus_addr[ADDR_W-1:3] and the word offset is bus_addr[2:0]. A bank holds NUM_SRC/32 enable words at offsets 0 to NUM_SRC/32-1, followed by the same number of status words. Bit i of enable or status word w corresponds to source 32*w+i. NUM_SRC is 32, 64 or 128.
- R2: After reset all enable bits are 0, every irq_out bit is 0, and bus_rdata is 0.
- R3: A write to an enable offset replaces the whole 32-bit word. A later read of that offset returns the value written.
- R4: A status word reads as the current source levels ANDed with the same-numbered enable word of that bank.
- R5: Writes to status offsets are ignored. Neither the enable words nor the status value read afterwards change.
- R6: irq_out[c] is a register. On each clock edge it loads the OR of all source levels ANDed with bank c's enables, so it follows its inputs one cycle later.
- R7: An enable bit in bank c affects only irq_out[c] and the status words of bank c.
- R8: bus_rdata takes the addressed word on the clock edge where bus_rd is high and holds its value while bus_rd is low.
- R9: Offsets at or above 2*NUM_SRC/32 inside a bank, and banks with an index of NUM_CPU or more, read as 0. Writes to them change nothing.
- R10: Status bits and irq_out are not latched. Once the source drops, the status reads 0 and irq_out falls one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address: bank index in the upper bits, word offset in the lower 3 bits |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid from the cycle after the read strobe |
| src_lvl | input | NUM_SRC | Level-sensitive interrupt sources, synchronous to clk |
| irq_out | output | NUM_CPU | One registered interrupt request per CPU |

## Verification
A corrupted enable bit is visible at the ports in two places. The affected CPU's irq_out is wrong one cycle after its source goes high, and a read of that enable or status word is wrong one cycle after the read strobe. A decode fault that sends a write to the wrong bank or offset shows up when the neighbouring bank's enable words are read back, and when an unmapped address reads nonzero. Leftover pending state shows up as an irq_out or status bit that stays high one cycle after every source has dropped.

// File: rtl/irq_fanout_pkg.sv
package irq_fanout_pkg;
    localparam int WORD_W = 32;
    localparam int OFF_W  = 3;  // fixed 8-word window per bank
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
    import irq_fanout_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int NWORD  = NUM_SRC / WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [OFF_W-1:0]   wr_off,
    input  word_t              wr_data,
    input  logic [NUM_SRC-1:0] src_lvl,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic               irq;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [NUM_SRC-1:0] pend;

    always_comb begin
        st_d     = st_q;
        pend     = src_lvl & st_q.en;
        st_d.irq = |pend;
        if (wr_en) begin
            for (int w = 0; w < NWORD; w++) begin
                if (wr_off == OFF_W'(w)) begin
                    st_d.en[w*WORD_W +: WORD_W] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign pend_o = pend;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
    import irq_fanout_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    parameter int BANK_W  = 2,
    localparam int NWORD  = NUM_SRC / WORD_W
) (
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0] en_all,
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0] pend_all,
    input  logic [BANK_W-1:0]               rd_bank,
    input  logic [OFF_W-1:0]                rd_off,
    output word_t                           rd_word
);
    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (rd_bank == BANK_W'(c)) begin
                for (int w = 0; w < NWORD; w++) begin
                    if (rd_off == OFF_W'(w)) begin
                        rd_word = en_all[c][w*WORD_W +: WORD_W];
                    end
                    if (rd_off == OFF_W'(NWORD + w)) begin
                        rd_word = pend_all[c][w*WORD_W +: WORD_W];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/irq_fanout_ctrl.sv
module irq_fanout_ctrl
    import irq_fanout_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_lvl,
    output logic [NUM_CPU-1:0] irq_out
);
    localparam int NWORD  = NUM_SRC / WORD_W;
    localparam int BANK_W = ADDR_W - OFF_W;

    typedef struct packed {
        word_t rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [BANK_W-1:0] a_bank;
    logic [OFF_W-1:0]  a_off;
    logic              a_en_off;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] en_all, pend_all;
    word_t             rd_word;

    assign a_bank   = bus_addr[ADDR_W-1:OFF_W];
    assign a_off    = bus_addr[OFF_W-1:0];
    assign a_en_off = (a_off < OFF_W'(NWORD));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        logic wr_sel;
        assign wr_sel = bus_wr && a_en_off && (a_bank == BANK_W'(c));
        irq_bank #(.NUM_SRC(NUM_SRC)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel),
            .wr_off  (a_off),
            .wr_data (bus_wdata),
            .src_lvl (src_lvl),
            .en_o    (en_all[c]),
            .pend_o  (pend_all[c]),
            .irq_o   (irq_out[c])
        );
    end

    irq_rd_mux #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU),
        .BANK_W  (BANK_W)
    ) rd_mux_i (
        .en_all   (en_all),
        .pend_all (pend_all),
        .rd_bank  (a_bank),
        .rd_off   (a_off),
        .rd_word  (rd_word)
    );

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/irq_fanout_chk.sv
module irq_fanout_chk #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    parameter int ADDR_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NUM_SRC-1:0] src_lvl,
    input logic [NUM_CPU-1:0] irq_out
);
    localparam int NW = NUM_SRC / 32;

    logic [NUM_CPU-1:0][NUM_SRC-1:0] shadow;
    logic [NUM_CPU-1:0]              exp_irq;
    logic [31:0]                     exp_rd;
    logic                            unmapped;
    int                              bk, of;

    assign bk = int'(bus_addr[ADDR_W-1:3]);
    assign of = int'(bus_addr[2:0]);
    assign unmapped = (bk >= NUM_CPU) || (of >= 2 * NW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (bus_wr) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                for (int w = 0; w < NW; w++) begin
                    if (bk == c && of == w) shadow[c][w*32 +: 32] <= bus_wdata;
                end
            end
        end
    end

    always_comb begin
        exp_rd = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            exp_irq[c] = |(src_lvl & shadow[c]);
            for (int w = 0; w < NW; w++) begin
                if (bk == c && of == w)      exp_rd = shadow[c][w*32 +: 32];
                if (bk == c && of == NW + w) exp_rd = src_lvl[w*32 +: 32] & shadow[c][w*32 +: 32];
            end
        end
    end

    // R6 R7 R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(exp_irq));

    // R3 R4 R5
    rd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rdata == $past(exp_rd));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> bus_rdata == '0);

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind irq_fanout_ctrl irq_fanout_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_lvl   (src_lvl),
    .irq_out   (irq_out)
);

// File: tb/irq_fanout_ctrl_tb.sv
module irq_fanout_ctrl_tb_top;
    localparam int NUM_SRC = 64;
    localparam int NUM_CPU = 2;
    localparam int ADDR_W  = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NUM_SRC-1:0] src_lvl = '0;
    logic [NUM_CPU-1:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    irq_fanout_ctrl #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_lvl(src_lvl), .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [63:0] lines;
        logic [63:0] en0;
        logic [63:0] en1;
        logic [1:0]  exp_irq;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{64'h0, {64{1'b1}}, {64{1'b1}}, 2'b00},
        '{64'h1, 64'h1, 64'h0, 2'b01},
        '{64'h8000_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000, 2'b10},
        '{64'h0000_0100_0000_0000, 64'h0000_0200_0000_0000, 64'h0000_0080_0000_0000, 2'b00},
        '{{64{1'b1}}, 64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000, 2'b11},
        '{64'h5, 64'h4, 64'h1, 2'b11}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        logic [63:0] en0, en1;

        repeat (3) @(negedge clk);
        // R2: state while and just after reset
        check("R2 irq in reset", 64'(irq_out), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 irq after reset", 64'(irq_out), 64'h0);
        check("R2 rdata after reset", 64'(bus_rdata), 64'h0);
        bus_read(5'd0, rd);  check("R2 en0 w0", 64'(rd), 64'h0);
        bus_read(5'd1, rd);  check("R2 en0 w1", 64'(rd), 64'h0);
        bus_read(5'd8, rd);  check("R2 en1 w0", 64'(rd), 64'h0);
        bus_read(5'd9, rd);  check("R2 en1 w1", 64'(rd), 64'h0);

        // R3 R1: whole-word enable write and readback at bank offsets
        bus_write(5'd0, 32'hA5A5_5A5A);
        bus_read(5'd0, rd);  check("R3 en0 w0 readback", 64'(rd), 64'hA5A5_5A5A);
        bus_write(5'd9, 32'h1234_5678);
        bus_read(5'd9, rd);  check("R3 R1 en1 w1 readback", 64'(rd), 64'h1234_5678);
        // R7: bank 1 write left bank 0 word 1 alone
        bus_read(5'd1, rd);  check("R7 en0 w1 untouched", 64'(rd), 64'h0);

        // R4 R6 R7 R1: table of routing patterns
        foreach (VECS[i]) begin
            en0 = VECS[i].en0;
            en1 = VECS[i].en1;
            bus_write(5'd0, en0[31:0]);
            bus_write(5'd1, en0[63:32]);
            bus_write(5'd8, en1[31:0]);
            bus_write(5'd9, en1[63:32]);
            src_lvl = VECS[i].lines;
            @(negedge clk);
            check($sformatf("R6 R7 irq vec %0d", i), 64'(irq_out), 64'(VECS[i].exp_irq));
            bus_read(5'd2, rd);  check($sformatf("R4 st0 w0 vec %0d", i), 64'(rd), 64'((VECS[i].lines & en0) & 64'hFFFF_FFFF));
            bus_read(5'd3, rd);  check($sformatf("R4 st0 w1 vec %0d", i), 64'(rd), (VECS[i].lines & en0) >> 32);
            bus_read(5'd10, rd); check($sformatf("R4 st1 w0 vec %0d", i), 64'(rd), 64'((VECS[i].lines & en1) & 64'hFFFF_FFFF));
            bus_read(5'd11, rd); check($sformatf("R4 st1 w1 vec %0d", i), 64'(rd), (VECS[i].lines & en1) >> 32);
        end

        // R5: status writes ignored
        bus_write(5'd0, 32'h0000_00FF);
        bus_write(5'd1, 32'h0);
        bus_write(5'd8, 32'h0);
        bus_write(5'd9, 32'h0);
        src_lvl = 64'h0F;
        bus_write(5'd2, 32'hFFFF_FFFF);
        bus_read(5'd0, rd);  check("R5 en0 w0 after status write", 64'(rd), 64'hFF);
        bus_read(5'd2, rd);  check("R5 st0 w0 after status write", 64'(rd), 64'h0F);

        // R9: unmapped offsets and banks
        bus_write(5'd4, 32'hFFFF_FFFF);
        bus_read(5'd4, rd);  check("R9 bank0 off4 reads 0", 64'(rd), 64'h0);
        bus_write(5'd16, 32'h0);
        bus_read(5'd0, rd);  check("R9 bank2 write no alias", 64'(rd), 64'hFF);
        bus_read(5'd17, rd); check("R9 bank2 reads 0", 64'(rd), 64'h0);
        bus_read(5'd15, rd); check("R9 bank1 off7 reads 0", 64'(rd), 64'h0);

        // R8: read data holds with no strobe
        bus_read(5'd0, rd);
        src_lvl = 64'h0;
        repeat (3) @(negedge clk);
        check("R8 rdata held", 64'(bus_rdata), 64'hFF);

        // R10 R6: level behaviour and one-cycle latency
        src_lvl = 64'h0F;
        @(negedge clk);
        check("R6 irq rises after one cycle", 64'(irq_out), 64'h1);
        src_lvl = 64'h0;
        check("R6 irq still high same cycle", 64'(irq_out), 64'h1);
        @(negedge clk);
        check("R10 irq falls after source drops", 64'(irq_out), 64'h0);
        bus_read(5'd2, rd);  check("R10 status not latched", 64'(rd), 64'h0);

        done = 1'b1;
        finish_run();
    end
endmodule